// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns the three address components of a storage operand into one byte address. The components are a base register value, an index register value and an instruction displacement. Each register operand can be forced to zero when the instruction names register zero. The sum is taken modulo the architected address width, so any carry past the top bit is lost. A program reaches lower addresses only through that wrap-around.

The low bits of the result that select real storage are then compared with the amount of memory fitted. That amount is a configuration input, counted in 4 KiB blocks. An address in a block that is not fitted raises an addressing exception, so it never aliases silently onto installed storage. The bits above the implemented storage width take no part in this check.

The result, the valid strobe and the exception flag are all registered, and they appear together one clock after the request.

Top module: `ea_gen`

## Requirements
- R1: `out_vld` is high in the cycle after each cycle with `in_vld` high, and low in the cycle after each cycle with `in_vld` low.
- R2: When `out_vld` is high, `ea` equals (base operand + index operand + displacement zero-extended to 24 bits) mod 2^24.
- R3: A carry out of bit 23 is discarded. For example, 0xFFFFFF + 0 + 0x001 gives 0x000000, and 0x000010 + 0xFFFFF8 + 0x000 gives 0x000008.
- R4: With `base_zero` high, the base operand is taken as zero whatever `base` holds.
- R5: With `index_zero` high, the index operand is taken as zero whatever `index` holds.
- R6: `addr_exc` is high exactly when `out_vld` is high and ea[17:12] (the 4 KiB block number) is greater than or equal to the `mem_blocks` value sampled with the request.
- R7: Bits 23..18 of `ea` play no part in the exception decision.
- R8: A `mem_blocks` value of 64 or more means every address is fitted. A value of 0 means every address raises the exception.
- R9: While `rst_n` is low, `out_vld` and `addr_exc` are 0 and `ea` is 0.
- R10: In a cycle that follows one with `in_vld` low, `ea` keeps its previous value and `addr_exc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Request strobe |
| base | input | 24 | Base register value |
| base_zero | input | 1 | Force base operand to zero |
| index | input | 24 | Index register value |
| index_zero | input | 1 | Force index operand to zero |
| disp | input | 12 | Unsigned displacement |
| mem_blocks | input | 7 | Installed memory, in 4 KiB blocks |
| out_vld | output | 1 | Address valid |
| ea | output | 24 | Wrapped effective address |
| addr_exc | output | 1 | Addressing exception, valid with out_vld |

## Verification
The embedded properties compare registered outputs with the previous cycle's inputs through `$past`. They therefore assume that `mem_blocks`, the operands and `in_vld` are settled at each rising edge, and that `in_vld` is held low for the whole of reset. The bench drives every input on the falling edge and keeps `in_vld` low until reset has been released. The bench also holds `mem_blocks` within its 7-bit range and lets it move between requests, so that the sampled value is the one that counts.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW = 24,
  parameter int DW = 12,
  parameter int IW = 18,
  parameter int PW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [AW-1:0]    base,
  input  logic             base_zero,
  input  logic [AW-1:0]    index,
  input  logic             index_zero,
  input  logic [DW-1:0]    disp,
  input  logic [IW-PW:0]   mem_blocks,
  output logic             out_vld,
  output logic [AW-1:0]    ea,
  output logic             addr_exc
);
  localparam int NBW = IW - PW;
  localparam int SZW = NBW + 1;

  logic [AW-1:0]  b_op, x_op, d_op, sum;
  logic [SZW-1:0] blk;
  logic           fitted;

  assign b_op   = base_zero  ? '0 : base;
  assign x_op   = index_zero ? '0 : index;
  assign d_op   = {{(AW-DW){1'b0}}, disp};
  assign sum    = b_op + x_op + d_op;
  assign blk    = {1'b0, sum[IW-1:PW]};
  assign fitted = blk < mem_blocks;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      addr_exc <= 1'b0;
      ea       <= '0;
    end else begin
      out_vld  <= in_vld;
      addr_exc <= in_vld & ~fitted;
      if (in_vld) ea <= sum;
    end
  end

  assert_vld_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  assert_vld_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  assert_exc_qual_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_exc |-> out_vld);
  assert_exc_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (addr_exc == ({1'b0, ea[IW-1:PW]} >= $past(mem_blocks))));
  assert_full_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && mem_blocks[NBW]) |=> !addr_exc);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(ea));
endmodule

// File: tb/sim_ea_gen.sv
module sim_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [23:0] base = '0, index = '0;
  logic        base_zero = 1'b0, index_zero = 1'b0;
  logic [11:0] disp = '0;
  logic [6:0]  mem_blocks = 7'd64;
  logic        out_vld, addr_exc;
  logic [23:0] ea;

  int tests = 0, fails = 0;
  bit exp_vld = 0, exp_exc = 0;
  longint exp_ea = 0;
  string  cur_tag = "R9";

  always #10 clk = ~clk;

  ea_gen u0 (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .base(base), .base_zero(base_zero),
             .index(index), .index_zero(index_zero), .disp(disp), .mem_blocks(mem_blocks),
             .out_vld(out_vld), .ea(ea), .addr_exc(addr_exc));

  task automatic chk(string tag, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk({cur_tag, "/R1 vld"}, out_vld, exp_vld);
    chk({cur_tag, "/R6 exc"}, addr_exc, exp_exc);
    chk({cur_tag, "/R2 ea"}, ea, exp_ea);
  endtask

  // drive one request (or idle) on the falling edge, then check after next rising edge
  task automatic step(bit v, longint b, bit bz, longint x, bit xz, int d, int mb, string tag);
    longint s;
    int blk;
    in_vld = v; base = b[23:0]; base_zero = bz; index = x[23:0]; index_zero = xz;
    disp = d[11:0]; mem_blocks = mb[6:0];
    s = ((bz ? 0 : b) + (xz ? 0 : x) + d) % 64'h1000000;
    blk = int'((s % 64'h40000) / 4096);
    exp_vld = v;
    exp_exc = v && (blk >= mb);
    if (v) exp_ea = s;
    cur_tag = tag;
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_tag = "R9";
    compare();
    rst_n = 1'b1;
    @(negedge clk);
    compare();
    step(1, 24'h001000, 0, 24'h000200, 0, 12'h034, 64, "R2");
    step(1, 24'h123456, 0, 24'h010101, 0, 12'hFFF, 64, "R2");
    step(1, 24'hFFFFFF, 0, 0, 0, 1, 64, "R3");
    step(1, 24'h000010, 0, 24'hFFFFF8, 0, 0, 64, "R3");
    step(1, 24'hABCDEF, 1, 24'h000100, 0, 12'h010, 64, "R4");
    step(1, 24'h000100, 0, 24'h777777, 1, 12'h010, 64, "R5");
    step(1, 24'h0AAAAA, 1, 24'h555555, 1, 12'h123, 64, "R5");
    step(1, 24'h007FFF, 0, 0, 0, 0, 8, "R6");
    step(1, 24'h008000, 0, 0, 0, 0, 8, "R6");
    step(1, 24'h03F000, 0, 0, 0, 0, 63, "R6");
    step(1, 24'hFC0000, 0, 0, 0, 0, 1, "R7");
    step(1, 24'hFC1000, 0, 0, 0, 0, 1, "R7");
    step(1, 24'h03FFFF, 0, 0, 0, 12'hFFF, 64, "R8");
    step(1, 24'h3FFFFF, 0, 0, 0, 0, 127, "R8");
    step(1, 0, 1, 0, 1, 0, 0, "R8");
    step(0, 24'h333333, 0, 24'h111111, 0, 12'h222, 0, "R10");
    step(0, 24'h444444, 0, 0, 0, 0, 0, "R10");
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 4) != 0, {$urandom} % 64'h1000000, ($urandom % 8) == 0,
           {$urandom} % 64'h1000000, ($urandom % 8) == 0, int'($urandom % 4096),
           int'($urandom % 80), "R2");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule